// File: doc/BRIEF.md
# Attribute Controller Register Port

This block is the processor-facing register port of a palette and attribute controller for a raster display. A single byte-wide write port does two jobs. An internal phase bit decides whether an incoming byte selects a register or supplies that register's value, and every accepted write flips the phase. A separate strobe, raised whenever the processor reads the display status port, puts the phase back to "select" so that software can always resynchronise.

The selector byte also carries a lock bit. While the lock bit is clear, the processor owns the sixteen palette entries and the display is blanked. While it is set, the palette is hidden from the processor and video is enabled. The five control registers (mode, border colour, plane enable, pixel pan and colour select) stay reachable in both cases. A read of a register that is hidden or absent returns the selector byte itself.

Each register has a change flag that tells downstream logic which entries need to be picked up again. Register contents after reset come from a preset set, chosen by an input that is sampled while reset is held.

Top module: `attr_regport`

## Requirements
- R1: While `rst_n` is low, on each clock the selector becomes 0, the lock bit becomes 1, the phase goes to select, every change flag becomes 1, and every register loads the preset chosen by `preset_sel`. The codes are 0 text, 1 four-colour, 2 sixteen-colour planar, 3 sixteen-colour 6-bit planar and 4 packed 8-bit; codes 5 to 7 behave as 0. Two examples: the mode register (index 0x10) holds 0x0C in the text preset and 0x41 in the 8-bit preset, and palette entry 1 holds 0x13 in the four-colour preset.
- R2: A write (`wr_en`) in select phase stores `wr_data[4:0]` as the selector and `wr_data[5]` as the lock bit, drops bits 7:6, and moves to value phase. A write in value phase targets the selected register and returns to select phase.
- R3: `stat_rd` forces select phase on the next edge. A write that arrives in the same cycle is discarded completely.
- R4: `rd_data` is combinational from the selector, the lock bit and the register contents. Reading never changes any state.
- R5: Palette entries 0x00 to 0x0F are accessible only while the lock bit is 0. Registers 0x10 to 0x14 are accessible whatever the lock bit is.
- R6: A read of an inaccessible entry, or of any selector above 0x14, returns {2'b00, lock bit, selector}.
- R7: A value-phase write to an inaccessible or absent register changes no register and no change flag, but it still returns the phase to select.
- R8: Stored values are masked. Index 0x10 clears bit 4, indices 0x13 and 0x14 keep bits 3:0, and every other register keeps bits 5:0. Cleared bits read as zero.
- R9: `video_on` equals the lock bit and changes only on a select-phase write.
- R10: An accepted value write that changes the stored value sets that register's change flag. A write of the same value does not set it.
- R11: An accepted value write to 0x10 or 0x14 sets the change flags of all sixteen palette entries, even when the value is unchanged.
- R12: `dirty_clr` clears every change flag on the next edge. A flag that is set by a write in the same cycle stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| preset_sel | input | 3 | Preset set loaded while in reset |
| wr_en | input | 1 | Write strobe for the shared select/value port |
| wr_data | input | 8 | Written byte |
| stat_rd | input | 1 | Status-port read strobe; forces select phase |
| dirty_clr | input | 1 | Clears all change flags |
| rd_data | output | 8 | Read value or echoed selector byte |
| video_on | output | 1 | Video enable, equal to the lock bit |
| dirty | output | 21 | Per-register change flags, bit n for index n |

## Verification
The assertions assume that the inputs are stable around the rising edge and that `wr_en`, `stat_rd` and `dirty_clr` are plain one-cycle levels with no meaning of their own during reset. The stimulus changes inputs only on the falling edge and holds reset for at least two edges. It mixes directed select/value sequences, including a strobe and a write in the same cycle, with long random runs. A behavioural model of the register port checks every output on every cycle.

// File: rtl/attr_pkg.sv
`timescale 1ns/1ps
package attr_pkg;

   localparam int unsigned AC_DW    = 8;
   localparam int unsigned AC_IDX_W = 5;
   localparam int unsigned AC_NPAL  = 16;
   localparam int unsigned AC_NCTL  = 5;

   typedef enum logic {
      PH_INDEX = 1'b0,
      PH_DATA  = 1'b1
   } phase_e;

   typedef enum logic [2:0] {
      PS_TEXT = 3'd0,
      PS_CGA  = 3'd1,
      PS_EGA  = 3'd2,
      PS_VGA  = 3'd3,
      PS_P8   = 3'd4
   } preset_e;

   // Bits that a register can hold; r is the register index, npal the palette size.
   function automatic logic [7:0] keep_mask(input int unsigned r, input int unsigned npal);
      if (r == npal)                          return 8'hEF;
      else if (r == npal + 3 || r == npal + 4) return 8'h0F;
      else                                    return 8'h3F;
   endfunction

   // Reset contents, computed from the preset code and register index.
   function automatic logic [7:0] preset_value(input logic [2:0] sel,
                                               input int unsigned r,
                                               input int unsigned npal);
      logic [7:0] v;
      logic [7:0] lo;
      lo = 8'(r % 8);
      v  = 8'h00;
      if (r < npal) begin
         case (sel)
            PS_CGA: begin
               if (r == 0)      v = 8'h00;
               else if (r < 4)  v = 8'(8'h11 + 2 * r);
               else if (r < 7)  v = 8'(2 * (r - 3));
               else if (r < 8)  v = 8'h07;
               else             v = 8'h10 + lo;
            end
            PS_EGA:  v = (r < 8) ? 8'(r) : (8'h10 + lo);
            PS_P8:   v = 8'(r);
            default: begin
               if (r == 6)      v = 8'h14;
               else if (r < 8)  v = 8'(r);
               else             v = 8'h38 + lo;
            end
         endcase
      end else begin
         case (r - npal)
            0: begin
               case (sel)
                  PS_CGA, PS_EGA, PS_VGA: v = 8'h01;
                  PS_P8:                  v = 8'h41;
                  default:                v = 8'h0C;
               endcase
            end
            2: v = (sel == PS_CGA) ? 8'h03 : 8'h0F;
            3: v = (sel == PS_CGA || sel == PS_EGA || sel == PS_VGA || sel == PS_P8) ? 8'h00 : 8'h08;
            default: v = 8'h00;
         endcase
      end
      return v & keep_mask(r, npal);
   endfunction

endpackage

// File: rtl/attr_toggle.sv
`timescale 1ns/1ps
module attr_toggle
   import attr_pkg::*;
#(
   parameter int unsigned DW    = AC_DW,
   parameter int unsigned IDX_W = AC_IDX_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             stat_rd,
   input  logic [DW-1:0]    wr_data,
   output phase_e           phase,
   output logic [IDX_W-1:0] sel_idx,
   output logic             lock,
   output logic             val_stb
);

   logic take;

   assign take    = wr_en && !stat_rd;
   assign val_stb = take && (phase == PH_DATA);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase   <= PH_INDEX;
         sel_idx <= '0;
         lock    <= 1'b1;
      end else if (stat_rd) begin
         phase <= PH_INDEX;
      end else if (wr_en) begin
         if (phase == PH_INDEX) begin
            sel_idx <= wr_data[IDX_W-1:0];
            lock    <= wr_data[IDX_W];
            phase   <= PH_DATA;
         end else begin
            phase <= PH_INDEX;
         end
      end
   end

endmodule

// File: rtl/attr_rdmux.sv
`timescale 1ns/1ps
module attr_rdmux #(
   parameter int unsigned DW    = 8,
   parameter int unsigned IDX_W = 5,
   parameter int unsigned NPAL  = 16,
   parameter int unsigned NREGS = 21
) (
   input  logic [IDX_W-1:0]           sel_idx,
   input  logic                       lock,
   input  logic [NREGS-1:0][DW-1:0]   regs,
   output logic                       acc,
   output logic [DW-1:0]              rd_data
);

   localparam logic [IDX_W:0] LIM_ALL = (IDX_W+1)'(NREGS);
   localparam logic [IDX_W:0] LIM_PAL = (IDX_W+1)'(NPAL);

   logic            exists;
   logic            is_pal;
   logic [DW-1:0]   pick;
   logic [DW-1:0]   echo;

   always_comb begin
      exists = {1'b0, sel_idx} < LIM_ALL;
      is_pal = {1'b0, sel_idx} < LIM_PAL;
      acc    = exists && (!lock || !is_pal);
      pick   = '0;
      for (int r = 0; r < NREGS; r++) begin
         if (sel_idx == IDX_W'(r)) pick = regs[r];
      end
      echo             = '0;
      echo[IDX_W-1:0]  = sel_idx;
      echo[IDX_W]      = lock;
      rd_data          = acc ? pick : echo;
   end

endmodule

// File: rtl/attr_regfile.sv
`timescale 1ns/1ps
module attr_regfile
   import attr_pkg::*;
#(
   parameter int unsigned DW    = 8,
   parameter int unsigned IDX_W = 5,
   parameter int unsigned NPAL  = 16,
   parameter int unsigned NREGS = 21
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [2:0]                 preset_sel,
   input  logic                       val_stb,
   input  logic                       acc,
   input  logic [IDX_W-1:0]           sel_idx,
   input  logic [DW-1:0]              wr_data,
   input  logic                       dirty_clr,
   output logic [NREGS-1:0][DW-1:0]   regs,
   output logic [NREGS-1:0]           dirty
);

   localparam logic [IDX_W-1:0] MODE_IX = IDX_W'(NPAL);
   localparam logic [IDX_W-1:0] CSEL_IX = IDX_W'(NPAL + 4);

   logic accepted;
   logic bulk;

   assign accepted = val_stb && acc;
   assign bulk     = accepted && (sel_idx == MODE_IX || sel_idx == CSEL_IX);

   for (genvar g = 0; g < NREGS; g++) begin : g_reg
      logic          hit;
      logic [DW-1:0] nv;
      logic          chg;
      logic          touch;

      assign hit = accepted && (sel_idx == IDX_W'(g));
      assign nv  = wr_data & DW'(keep_mask(g, NPAL));
      assign chg = hit && (nv != regs[g]);

      if (g < NPAL) begin : g_pal
         assign touch = chg || bulk;
      end else begin : g_ctl
         assign touch = chg;
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            regs[g]  <= DW'(preset_value(preset_sel, g, NPAL));
            dirty[g] <= 1'b1;
         end else begin
            if (hit) regs[g] <= nv;
            if (touch)          dirty[g] <= 1'b1;
            else if (dirty_clr) dirty[g] <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/attr_regport.sv
`timescale 1ns/1ps
module attr_regport
   import attr_pkg::*;
#(
   parameter int unsigned DW    = AC_DW,
   parameter int unsigned IDX_W = AC_IDX_W,
   parameter int unsigned NPAL  = AC_NPAL,
   parameter int unsigned NCTL  = AC_NCTL
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [2:0]             preset_sel,
   input  logic                   wr_en,
   input  logic [DW-1:0]          wr_data,
   input  logic                   stat_rd,
   input  logic                   dirty_clr,
   output logic [DW-1:0]          rd_data,
   output logic                   video_on,
   output logic [NPAL+NCTL-1:0]   dirty
);

   localparam int unsigned NREGS = NPAL + NCTL;

   if (NREGS > (1 << IDX_W)) begin : g_bad_idx
      $error("attr_regport: register count does not fit the selector width");
   end
   if (DW != 8) begin : g_bad_dw
      $error("attr_regport: register masks assume an 8-bit data path");
   end
   if (NCTL != 5) begin : g_bad_ctl
      $error("attr_regport: exactly five control registers are supported");
   end
   if (IDX_W + 1 > DW) begin : g_bad_lock
      $error("attr_regport: lock bit must fit in the written byte");
   end

   phase_e                    tg_phase;
   logic [IDX_W-1:0]          sel_idx;
   logic                      lock;
   logic                      val_stb;
   logic                      acc;
   logic [NREGS-1:0][DW-1:0]  regs;

   attr_toggle #(.DW(DW), .IDX_W(IDX_W)) u_toggle (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .stat_rd (stat_rd),
      .wr_data (wr_data),
      .phase   (tg_phase),
      .sel_idx (sel_idx),
      .lock    (lock),
      .val_stb (val_stb)
   );

   attr_rdmux #(.DW(DW), .IDX_W(IDX_W), .NPAL(NPAL), .NREGS(NREGS)) u_rdmux (
      .sel_idx (sel_idx),
      .lock    (lock),
      .regs    (regs),
      .acc     (acc),
      .rd_data (rd_data)
   );

   attr_regfile #(.DW(DW), .IDX_W(IDX_W), .NPAL(NPAL), .NREGS(NREGS)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .preset_sel (preset_sel),
      .val_stb    (val_stb),
      .acc        (acc),
      .sel_idx    (sel_idx),
      .wr_data    (wr_data),
      .dirty_clr  (dirty_clr),
      .regs       (regs),
      .dirty      (dirty)
   );

   assign video_on = lock;

endmodule

// File: rtl/attr_regport_chk.sv
`timescale 1ns/1ps
module attr_regport_chk #(
   parameter int unsigned DW    = 8,
   parameter int unsigned IDX_W = 5,
   parameter int unsigned NPAL  = 16,
   parameter int unsigned NREGS = 21
) (
   input logic               clk,
   input logic               rst_n,
   input logic               wr_en,
   input logic [DW-1:0]      wr_data,
   input logic               stat_rd,
   input logic               dirty_clr,
   input logic [DW-1:0]      rd_data,
   input logic               video_on,
   input logic [NREGS-1:0]   dirty,
   input logic               in_val_phase,
   input logic [IDX_W-1:0]   cur_idx
);

   localparam logic [IDX_W-1:0] LAST_IX = IDX_W'(NREGS - 1);
   localparam logic [IDX_W-1:0] PAL_IX  = IDX_W'(NPAL);
   localparam logic [IDX_W-1:0] PAN_IX  = IDX_W'(NPAL + 3);
   localparam logic [IDX_W-1:0] CSEL_IX = IDX_W'(NPAL + 4);

   // R3
   stat_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stat_rd |=> !in_val_phase);

   // R2
   sel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !stat_rd && !in_val_phase) |=>
         (in_val_phase && cur_idx == $past(wr_data[IDX_W-1:0]) && video_on == $past(wr_data[IDX_W])));

   // R2
   val_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !stat_rd && in_val_phase) |=> !in_val_phase);

   // R6
   absent_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_idx > LAST_IX) |->
         (rd_data[IDX_W-1:0] == cur_idx && rd_data[IDX_W] == video_on && rd_data[DW-1:IDX_W+1] == '0));

   // R8
   narrow_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_idx == PAN_IX || cur_idx == CSEL_IX) |-> rd_data[DW-1:4] == '0);

   // R8
   mode_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_idx == PAL_IX) |-> !rd_data[4]);

   // R12
   clr_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dirty_clr && !wr_en) |=> dirty == '0);

   // R7
   locked_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !stat_rd && in_val_phase && video_on && cur_idx < PAL_IX && !dirty_clr)
         |=> $stable(dirty));

   // R9
   video_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && !stat_rd && !in_val_phase) |=> $stable(video_on));

endmodule

bind attr_regport attr_regport_chk #(
   .DW(DW), .IDX_W(IDX_W), .NPAL(NPAL), .NREGS(NPAL + NCTL)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .wr_en        (wr_en),
   .wr_data      (wr_data),
   .stat_rd      (stat_rd),
   .dirty_clr    (dirty_clr),
   .rd_data      (rd_data),
   .video_on     (video_on),
   .dirty        (dirty),
   .in_val_phase (tg_phase == attr_pkg::PH_DATA),
   .cur_idx      (sel_idx)
);

// File: tb/tb_attr_regport.sv
`timescale 1ns/1ps
module tb_attr_regport;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  preset_sel = 3'd0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_data = 8'h00;
   logic        stat_rd = 1'b0;
   logic        dirty_clr = 1'b0;
   logic [7:0]  rd_data;
   logic        video_on;
   logic [20:0] dirty;

   int n_run = 0;
   int n_fail = 0;
   bit cmp_en = 1'b0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   attr_regport dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .preset_sel (preset_sel),
      .wr_en      (wr_en),
      .wr_data    (wr_data),
      .stat_rd    (stat_rd),
      .dirty_clr  (dirty_clr),
      .rd_data    (rd_data),
      .video_on   (video_on),
      .dirty      (dirty)
   );

   // ---------------- reference model ----------------
   logic [7:0]  m_reg [0:20];
   int          m_idx;
   bit          m_lock;
   bit          m_val;
   logic [20:0] m_dirty;

   function automatic logic [7:0] ref_init(int p, int r);
      int lo;
      lo = r % 8;
      if (r == 16) begin
         if (p == 4) return 8'h41;
         if (p >= 1 && p <= 3) return 8'h01;
         return 8'h0C;
      end
      if (r == 18) return (p == 1) ? 8'h03 : 8'h0F;
      if (r == 19) return (p >= 1 && p <= 4) ? 8'h00 : 8'h08;
      if (r > 15) return 8'h00;
      if (p == 4) return 8'(r);
      if (p == 2) return (r < 8) ? 8'(r) : 8'(16 + lo);
      if (p == 1) begin
         case (r)
            0: return 8'h00;
            1: return 8'h13;
            2: return 8'h15;
            3: return 8'h17;
            4: return 8'h02;
            5: return 8'h04;
            6: return 8'h06;
            7: return 8'h07;
            default: return 8'(16 + lo);
         endcase
      end
      if (r == 6) return 8'h14;
      return (r < 8) ? 8'(r) : 8'(56 + lo);
   endfunction

   function automatic logic [7:0] ref_mask(int r);
      if (r == 16) return 8'hEF;
      if (r == 19 || r == 20) return 8'h0F;
      return 8'h3F;
   endfunction

   function automatic bit ref_acc(int i, bit lk);
      return (i <= 20) && (!lk || i >= 16);
   endfunction

   function automatic logic [7:0] ref_rd();
      if (ref_acc(m_idx, m_lock)) return m_reg[m_idx];
      return 8'(m_idx) | (m_lock ? 8'h20 : 8'h00);
   endfunction

   always @(posedge clk) begin
      logic [20:0] setv;
      logic [7:0]  nv;
      setv = '0;
      if (!rst_n) begin
         for (int r = 0; r < 21; r++) m_reg[r] = ref_init(int'(preset_sel), r);
         m_idx = 0; m_lock = 1'b1; m_val = 1'b0; m_dirty = '1;
      end else begin
         if (stat_rd) begin
            m_val = 1'b0;
         end else if (wr_en) begin
            if (!m_val) begin
               m_idx  = int'(wr_data[4:0]);
               m_lock = wr_data[5];
               m_val  = 1'b1;
            end else begin
               m_val = 1'b0;
               if (ref_acc(m_idx, m_lock)) begin
                  nv = wr_data & ref_mask(m_idx);
                  if (nv != m_reg[m_idx]) begin
                     m_reg[m_idx] = nv;
                     setv[m_idx]  = 1'b1;
                  end
                  if (m_idx == 16 || m_idx == 20) setv[15:0] = '1;
               end
            end
         end
         m_dirty = (dirty_clr ? 21'd0 : m_dirty) | setv;
      end
   end

   // ---------------- checking ----------------
   task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (cmp_en && !done) begin
         check(rd_data === ref_rd(), "R4 read path", 32'(rd_data), 32'(ref_rd()));
         check(video_on === m_lock, "R9 video enable", 32'(video_on), 32'(m_lock));
         check(dirty === m_dirty, "R10 change flags", 32'(dirty), 32'(m_dirty));
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic drive(bit we, logic [7:0] d, bit sr, bit clr);
      @(negedge clk);
      wr_en = we; wr_data = d; stat_rd = sr; dirty_clr = clr;
   endtask

   task automatic idle();
      drive(1'b0, 8'h00, 1'b0, 1'b0);
   endtask

   task automatic do_reset(logic [2:0] p);
      @(negedge clk);
      rst_n = 1'b0; preset_sel = p;
      wr_en = 1'b0; stat_rd = 1'b0; dirty_clr = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      cmp_en = 1'b1;
   endtask

   task automatic put(logic [7:0] sel, logic [7:0] val);
      drive(1'b1, sel, 1'b0, 1'b0);
      drive(1'b1, val, 1'b0, 1'b0);
      idle();
   endtask

   task automatic sel_only(logic [7:0] sel);
      drive(1'b1, sel, 1'b0, 1'b0);
      drive(1'b0, 8'h00, 1'b1, 1'b0);
      idle();
   endtask

   // ---------------- main sequence ----------------
   initial begin
      do_reset(3'd0);
      idle();
      // R1 reset state
      check(video_on === 1'b1, "R1 lock after reset", 32'(video_on), 32'd1);
      check(dirty === 21'h1FFFFF, "R1 flags after reset", 32'(dirty), 32'h1FFFFF);
      // R6 selector 0 locked, echoes 0x20
      check(rd_data === 8'h20, "R6 echo after reset", 32'(rd_data), 32'h20);

      // R9 / R5 border register, palette unlocked
      sel_only(8'h11);
      check(video_on === 1'b0, "R9 video blanked", 32'(video_on), 32'd0);
      check(rd_data === 8'h00, "R5 border readable", 32'(rd_data), 32'h00);

      // R8 masks
      put(8'h11, 8'hFF);
      sel_only(8'h11);
      check(rd_data === 8'h3F, "R8 six-bit mask", 32'(rd_data), 32'h3F);
      put(8'h30, 8'hFF);
      check(rd_data === 8'hEF, "R8 mode mask and R5 locked access", 32'(rd_data), 32'hEF);
      put(8'h33, 8'hFF);
      check(rd_data === 8'h0F, "R8 pan mask", 32'(rd_data), 32'h0F);

      // R7 locked palette write dropped
      put(8'h25, 8'h2A);
      check(rd_data === 8'h25, "R6 locked palette echo", 32'(rd_data), 32'h25);
      sel_only(8'h05);
      check(rd_data === 8'h05, "R7 locked write ignored", 32'(rd_data), 32'h05);
      put(8'h1C, 8'h11);
      check(rd_data === 8'h1C, "R7 absent register echo", 32'(rd_data), 32'h1C);
      drive(1'b1, 8'h07, 1'b0, 1'b0);
      idle();
      check(rd_data === 8'h07, "R7 phase back to select", 32'(rd_data), 32'h07);

      // R3 status strobe
      drive(1'b1, 8'h13, 1'b0, 1'b0);
      drive(1'b0, 8'h00, 1'b1, 1'b0);
      drive(1'b1, 8'h09, 1'b0, 1'b0);
      idle();
      check(rd_data === 8'h39, "R3 strobe resets phase", 32'(rd_data), 32'h39);
      drive(1'b1, 8'h14, 1'b0, 1'b0);
      drive(1'b1, 8'h0A, 1'b1, 1'b0);
      drive(1'b1, 8'h14, 1'b0, 1'b0);
      idle();
      check(rd_data === 8'h00, "R3 same-cycle write discarded", 32'(rd_data), 32'h00);

      // R12 / R10 / R11 change flags
      drive(1'b0, 8'h00, 1'b1, 1'b1);
      idle();
      check(dirty === 21'd0, "R12 clear", 32'(dirty), 32'd0);
      put(8'h11, 8'h3F);
      check(dirty === 21'd0, "R10 same value no flag", 32'(dirty), 32'd0);
      put(8'h12, 8'h05);
      check(dirty === 21'h040000, "R10 changed value flag", 32'(dirty), 32'h040000);
      drive(1'b1, 8'h14, 1'b0, 1'b1);
      drive(1'b1, 8'h00, 1'b0, 1'b1);
      idle();
      check(dirty === 21'h00FFFF, "R11 and R12 bulk set wins over clear", 32'(dirty), 32'h00FFFF);

      // R1 presets and a full read scan per preset
      for (int p = 0; p < 6; p++) begin
         do_reset(3'(p));
         idle();
         for (int i = 0; i < 32; i++) begin
            sel_only(8'(i));
            sel_only(8'(i) | 8'h20);
         end
      end
      do_reset(3'd1);
      sel_only(8'h01);
      check(rd_data === 8'h13, "R1 four-colour preset", 32'(rd_data), 32'h13);
      do_reset(3'd4);
      sel_only(8'h10);
      check(rd_data === 8'h41, "R1 8-bit preset mode", 32'(rd_data), 32'h41);
      do_reset(3'd7);
      sel_only(8'h10);
      check(rd_data === 8'h0C, "R1 unused code acts as text", 32'(rd_data), 32'h0C);

      // random traffic, checked against the model each cycle (R2 R4 R5 R10)
      do_reset(3'd3);
      for (int n = 0; n < 4000; n++) begin
         drive(($urandom % 2) == 0, 8'($urandom), ($urandom % 20) == 0, ($urandom % 25) == 0);
      end
      idle();
      idle();

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         done = 1'b1;
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule